// File: doc/BRIEF.md
# Palette Entry Colour Converter

This block takes the raw palette words that a fetch engine reads from memory for an indexed-colour display mode and turns each one into a common internal form: 8-bit red, green and blue plus a transparency flag. The results go out through a write port into a 256-entry palette RAM, which the pixel lookup stage reads later.

A load begins with a `start` pulse. At that edge the block captures the pixel depth code, the palette format and the grayscale flag. It then accepts one raw word for each cycle in which `in_valid` is high, and writes each converted entry to the next palette address, counting up from 0. After the last entry has been written it pulses `done`. The depth code sets how many entries a load takes. One depth code means direct colour: a start with that code writes nothing and only returns a `done` pulse. A `need_reload` level tells the surrounding controller when the live format selection no longer matches the format used by the last indexed load. That signal is what triggers a reconversion.

Top module: `pal_convert`

## Requirements
- R1: While reset is held and in the first cycle after it, `pal_we` and `done` are low and `need_reload` is high.
- R2: The depth code sets the entry count: 0 gives 4 entries (2 bpp), 1 gives 16 (4 bpp), 2 gives 256 (8 bpp). Entries go to addresses 0, 1, 2 and so on in order. An `in_valid` cycle outside a load, or beyond the last entry, writes nothing.
- R3: A start with depth code 3 (direct colour) writes no entry. It raises `done` for one cycle, in the second cycle after the start edge.
- R4: Format 0 reads a 16-bit 5-6-5 entry. Red is word[15:11] placed in R[7:3], green is word[10:5] placed in G[7:2], blue is word[4:0] placed in B[7:3]. The low bits are zero and transparency is 0.
- R5: Format 1 reads red from word[23:19] into R[7:3], green from word[15:10] into G[7:2] and blue from word[7:3] into B[7:3]. The low bits are zero and transparency is word[24].
- R6: Format 2 reads red from word[23:18], green from word[15:10] and blue from word[7:2], each placed in bits [7:2] of its output. The low two bits are zero and transparency is word[24].
- R7: Format 3 reads R = word[23:16], G = word[15:8] and B = word[7:0]. Transparency is word[24].
- R8: When grayscale is selected, R, G and B all equal word[7:0]. Transparency is unchanged: word[24] for formats 1 to 3, and 0 for format 0.
- R9: A word accepted at one clock edge is written at the next edge. At that point `pal_we` is high and `pal_data` holds transparency in bit 24, R in bits 23:16, G in bits 15:8 and B in bits 7:0.
- R10: `done` goes high for exactly one cycle, in the cycle after the last write. It is never high at the same time as `pal_we`.
- R11: A `start` that arrives while a load is running, or before that load's `done` pulse, is ignored. The running load keeps its own format, grayscale setting and address sequence.
- R12: `need_reload` is high until an indexed load completes. After that it is high exactly when the live `fmt` input differs from the format that load used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a palette load |
| depth | input | 2 | Pixel depth code, captured at start |
| fmt | input | 2 | Palette format, captured at start and compared live |
| gray | input | 1 | Grayscale override, captured at start |
| in_valid | input | 1 | Raw palette word present |
| in_word | input | 25 | Low 25 bits of a raw palette word |
| pal_we | output | 1 | Palette RAM write enable |
| pal_addr | output | 8 | Palette RAM address |
| pal_data | output | 25 | Converted entry {transparency, R, G, B} |
| done | output | 1 | Load finished pulse |
| need_reload | output | 1 | Format changed since last indexed load |

## Verification
The bench targets the bit slicing of each format, both with and without grayscale. A swapped or shifted field would put wrong colour bits or a stray transparency flag into the palette. It checks the entry count at all three indexed depths and inserts random idle gaps between words: a wrong limit would stop the load early or let writes run past the table, and a missing gate would turn an idle cycle into a write. A second start is injected in the middle of a load; a design that accepted it would restart at address 0 or switch formats partway through. The bench also checks the timing of `done` for direct-colour starts and the `need_reload` level after the format input changes.

// File: rtl/pal_convert.sv
module pal_convert #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        depth,
  input  logic [1:0]        fmt,
  input  logic              gray,
  input  logic              in_valid,
  input  logic [24:0]       in_word,
  output logic              pal_we,
  output logic [ADDR_W-1:0] pal_addr,
  output logic [24:0]       pal_data,
  output logic              done,
  output logic              need_reload
);
  localparam logic [ADDR_W-1:0] LIM_2 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] LIM_4 = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] LIM_8 = '1;

  logic              busy, last_q, have_fmt, gray_q;
  logic [1:0]        fmt_q, used_fmt;
  logic [ADDR_W-1:0] cnt, lim;
  logic [7:0]        r, g, b;
  logic              t;

  wire accept    = busy & in_valid;
  wire can_start = start & ~busy & ~last_q;

  always_comb begin
    unique case (fmt_q)
      2'd0: begin
        r = {in_word[15:11], 3'b0};
        g = {in_word[10:5], 2'b0};
        b = {in_word[4:0], 3'b0};
        t = 1'b0;
      end
      2'd1: begin
        r = {in_word[23:19], 3'b0};
        g = {in_word[15:10], 2'b0};
        b = {in_word[7:3], 3'b0};
        t = in_word[24];
      end
      2'd2: begin
        r = {in_word[23:18], 2'b0};
        g = {in_word[15:10], 2'b0};
        b = {in_word[7:2], 2'b0};
        t = in_word[24];
      end
      default: begin
        r = in_word[23:16];
        g = in_word[15:8];
        b = in_word[7:0];
        t = in_word[24];
      end
    endcase
    if (gray_q) begin
      r = in_word[7:0];
      g = in_word[7:0];
      b = in_word[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      last_q   <= 1'b0;
      have_fmt <= 1'b0;
      gray_q   <= 1'b0;
      fmt_q    <= 2'd0;
      used_fmt <= 2'd0;
      cnt      <= '0;
      lim      <= '0;
      pal_we   <= 1'b0;
      pal_addr <= '0;
      pal_data <= '0;
      done     <= 1'b0;
    end else begin
      pal_we <= accept;
      done   <= last_q;
      last_q <= 1'b0;
      if (can_start) begin
        fmt_q  <= fmt;
        gray_q <= gray;
        cnt    <= '0;
        unique case (depth)
          2'd0: lim <= LIM_2;
          2'd1: lim <= LIM_4;
          default: lim <= LIM_8;
        endcase
        if (depth == 2'd3) last_q <= 1'b1;
        else               busy   <= 1'b1;
      end
      if (accept) begin
        pal_addr <= cnt;
        pal_data <= {t, r, g, b};
        cnt      <= cnt + 1'b1;
        if (cnt == lim) begin
          busy     <= 1'b0;
          last_q   <= 1'b1;
          used_fmt <= fmt_q;
          have_fmt <= 1'b1;
        end
      end
    end
  end

  assign need_reload = ~have_fmt | (fmt != used_fmt);

  p_we_follows_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> $past(in_valid));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we && $past(pal_we) && pal_addr != '0) |-> pal_addr == $past(pal_addr) + 1'b1);
  p_addr_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> pal_addr <= lim);
  p_done_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pal_we);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_gray_equal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_we && gray_q) |-> (pal_data[23:16] == pal_data[15:8] && pal_data[15:8] == pal_data[7:0]));
endmodule

// File: tb/pal_convert_tb.sv
`timescale 1ns/1ps
module pal_convert_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, gray, in_valid;
  logic [1:0]  depth, fmt;
  logic [24:0] in_word;
  logic        pal_we, done, need_reload;
  logic [7:0]  pal_addr;
  logic [24:0] pal_data;
  int checks = 0;
  int errors = 0;

  pal_convert u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .fmt(fmt),
    .gray(gray), .in_valid(in_valid), .in_word(in_word), .pal_we(pal_we),
    .pal_addr(pal_addr), .pal_data(pal_data), .done(done),
    .need_reload(need_reload)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [24:0] model(input logic [24:0] w, input logic [1:0] f,
                                        input logic gy);
    logic [7:0] r, g, b;
    logic t;
    case (f)
      2'd0: begin r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0}; t = 1'b0; end
      2'd1: begin r = {w[23:19], 3'b0}; g = {w[15:10], 2'b0}; b = {w[7:3], 3'b0}; t = w[24]; end
      2'd2: begin r = {w[23:18], 2'b0}; g = {w[15:10], 2'b0}; b = {w[7:2], 2'b0}; t = w[24]; end
      default: begin r = w[23:16]; g = w[15:8]; b = w[7:0]; t = w[24]; end
    endcase
    if (gy) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {t, r, g, b};
  endfunction

  function automatic string fmt_req(input logic [1:0] f, input logic gy);
    if (gy) return "R8";
    case (f)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_load(input logic [1:0] d, input logic [1:0] f, input logic gy,
                          input bit inject, input bit pattern);
    int n;
    logic [24:0] w;
    n = (d == 2'd0) ? 4 : (d == 2'd1) ? 16 : 256;
    start = 1'b1; depth = d; fmt = f; gray = gy; in_valid = 1'b0;
    step();
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      while ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        in_word = 25'($urandom);
        step();
        chk(pal_we == 1'b0, "R2", "write during gap", 32'(pal_we), 32'd0);
      end
      if (pattern) w = (i % 2 == 0) ? 25'h1FFFFFF : 25'h1000000;
      else         w = 25'($urandom);
      in_word = w;
      in_valid = 1'b1;
      if (inject && i == n / 2) begin
        start = 1'b1; fmt = ~f; gray = ~gy; depth = 2'd0;
      end
      step();
      in_valid = 1'b0; start = 1'b0; fmt = f; gray = gy; depth = d;
      chk(pal_we == 1'b1, "R9", "write enable", 32'(pal_we), 32'd1);
      chk(pal_addr == 8'(i), (inject && i > n / 2) ? "R11" : "R2", "address",
          32'(pal_addr), 32'(i));
      chk(pal_data == model(w, f, gy), (inject && i > n / 2) ? "R11" : fmt_req(f, gy),
          "entry", 32'(pal_data), 32'(model(w, f, gy)));
      if (i != n - 1)
        chk(done == 1'b0, "R10", "early done", 32'(done), 32'd0);
    end
    step();
    chk(done == 1'b1, "R10", "done after last", 32'(done), 32'd1);
    chk(pal_we == 1'b0, "R2", "no extra write", 32'(pal_we), 32'd0);
    step();
    chk(done == 1'b0, "R10", "done width", 32'(done), 32'd0);
    chk(need_reload == 1'b0, "R12", "reload after load", 32'(need_reload), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    rst_n = 1'b0; start = 1'b0; depth = 2'd0; fmt = 2'd0; gray = 1'b0;
    in_valid = 1'b0; in_word = '0;
    repeat (3) step();
    chk(pal_we == 1'b0, "R1", "reset we", 32'(pal_we), 32'd0);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 32'd0);
    chk(need_reload == 1'b1, "R1", "reset reload", 32'(need_reload), 32'd1);
    rst_n = 1'b1;
    step();
    chk(pal_we == 1'b0 && done == 1'b0, "R1", "post reset", 32'({pal_we, done}), 32'd0);
    chk(need_reload == 1'b1, "R12", "no load yet", 32'(need_reload), 32'd1);

    in_valid = 1'b1; in_word = 25'h0ABCDEF;
    repeat (3) begin
      step();
      chk(pal_we == 1'b0, "R2", "idle valid ignored", 32'(pal_we), 32'd0);
    end
    in_valid = 1'b0;

    for (int f = 0; f < 4; f++) run_load(2'd0, 2'(f), 1'b0, 1'b0, 1'b0);
    for (int f = 0; f < 4; f++) run_load(2'd1, 2'(f), 1'b1, 1'b0, 1'b0);
    run_load(2'd1, 2'd1, 1'b0, 1'b0, 1'b1);
    run_load(2'd0, 2'd0, 1'b1, 1'b0, 1'b1);
    run_load(2'd2, 2'd2, 1'b0, 1'b1, 1'b0);
    run_load(2'd2, 2'd3, 1'b1, 1'b0, 1'b0);

    fmt = 2'd1;
    #1;
    chk(need_reload == 1'b1, "R12", "format changed", 32'(need_reload), 32'd1);
    fmt = 2'd3;
    #1;
    chk(need_reload == 1'b0, "R12", "format restored", 32'(need_reload), 32'd0);

    start = 1'b1; depth = 2'd3; fmt = 2'd3;
    step();
    start = 1'b0;
    chk(pal_we == 1'b0 && done == 1'b0, "R3", "direct first cycle", 32'({pal_we, done}), 32'd0);
    step();
    chk(done == 1'b1 && pal_we == 1'b0, "R3", "direct done", 32'({pal_we, done}), 32'd1);
    step();
    chk(done == 1'b0, "R3", "direct done width", 32'(done), 32'd0);

    in_valid = 1'b1;
    repeat (2) begin
      step();
      chk(pal_we == 1'b0, "R3", "no write after direct", 32'(pal_we), 32'd0);
    end
    in_valid = 1'b0;
    finish_run();
  end
endmodule